// File: doc/BRIEF.md
# Premodulated Waveform Word Generator

This block feeds a radio-frequency bit serializer with 32-bit words that are already modulated. A request names a signal level (4-bit code) and a word count. The block then streams that many words over a valid/ready interface. Each word is looked up in an internal table whose rows are carrier phase steps and whose columns are level codes.

The carrier phase row advances by one for every word the consumer accepts. It wraps to the first row after the last row. The phase is never reset between requests, so consecutive segments of a line, and consecutive lines, join without a phase jump.

A jam request ignores the supplied count and level. It fills a whole line of words with one fixed test level. A one-cycle done pulse marks the end of every request.

Top module: `premod_wordgen`

## Requirements
- R1: After reset, `word_valid` and `done` are 0, `req_ready` is 1, and the first word emitted uses phase row 0.
- R2: Each word has the form {row[7:0], level[7:0], 16'hC3A5}, where row is the current phase row and level is the request's 4-bit level code zero-extended to 8 bits.
- R3: After each accepted word (`word_valid` and `word_ready` both high at a clock edge), the phase row becomes (row+1) modulo PHASES, so row PHASES-1 is followed by row 0.
- R4: While `word_valid` is high and `word_ready` is low, the word and the phase row do not change.
- R5: The phase row carries over unchanged from the last word of one request to the first word of the next.
- R6: A normal request (`req_jam`=0) with `req_count`=N>0 produces exactly N words, all at `req_level`.
- R7: A jam request (`req_jam`=1) produces exactly LINE_WORDS words, all at `jam_level`. `req_count` and `req_level` are ignored.
- R8: `done` is high for exactly one cycle, in the cycle after the clock edge that accepted the last word, and `word_valid` is then low.
- R9: A normal request with `req_count`=0 raises `done` in the next cycle, emits no words and leaves the phase row unchanged.
- R10: While a request is in progress, `req_ready` is 0 and `req_valid` has no effect on the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_ready | output | 1 | Block is idle and can take a request |
| req_count | input | CNT_W | Number of words for a normal request |
| req_level | input | 4 | Level code for a normal request |
| req_jam | input | 1 | Jam request: full line at jam_level |
| jam_level | input | 4 | Level code used by jam requests |
| word_valid | output | 1 | Output word is valid |
| word_ready | input | 1 | Consumer accepts the word |
| word_data | output | 32 | Premodulated word |
| done | output | 1 | One-cycle end-of-request pulse |

## Verification
A wrong phase register shows up at once in the row byte of the next word, because the row is encoded in every word. A skipped or doubled step is therefore visible one accepted word after the fault. A wrong word counter shows up as a missing or extra word before `done`, or as `done` arriving in the wrong cycle. A wrong level register shows up in the level byte of the first word of the request. A stall-handling fault shows up in the first stalled cycle, as a changed word or a shifted phase sequence after the stall.

// File: rtl/premod_pkg.sv
package premod_pkg;
    localparam int LEVEL_W  = 4;
    localparam int WORD_W   = 32;
    localparam int FIELD_W  = 8;
    localparam logic [15:0] TABLE_PAD = 16'hC3A5;
endpackage

// File: rtl/premod_rom.sv
module premod_rom
    import premod_pkg::*;
#(
    parameter int PHASES = 7,
    localparam int ROW_W = (PHASES > 1) ? $clog2(PHASES) : 1,
    localparam int LEVELS = 1 << LEVEL_W
) (
    input  logic [ROW_W-1:0]   row,
    input  logic [LEVEL_W-1:0] level,
    output logic [WORD_W-1:0]  word
);
    logic [WORD_W-1:0] table_w [PHASES][LEVELS];

    // Placeholder contents: row and level are encoded in the word itself.
    for (genvar r = 0; r < PHASES; r++) begin : g_row
        for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
            assign table_w[r][l] = {FIELD_W'(r), FIELD_W'(l), TABLE_PAD};
        end
    end

    always_comb begin
        word = '0;
        for (int r = 0; r < PHASES; r++) begin
            if (row == ROW_W'(r)) word = table_w[r][level];
        end
    end
endmodule

// File: rtl/premod_phase.sv
module premod_phase #(
    parameter int PHASES = 7,
    localparam int ROW_W = (PHASES > 1) ? $clog2(PHASES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [ROW_W-1:0] row
);
    logic [ROW_W-1:0] row_d, row_q;

    always_comb begin
        row_d = row_q;
        if (adv) begin
            // Step one row; wrap past the last row back to the first.
            row_d = (row_q == ROW_W'(PHASES - 1)) ? '0 : row_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) row_q <= '0;
        else        row_q <= row_d;
    end

    assign row = row_q;
endmodule

// File: rtl/premod_wordgen.sv
module premod_wordgen
    import premod_pkg::*;
#(
    parameter int PHASES     = 7,
    parameter int CNT_W      = 8,
    parameter int LINE_WORDS = 159,
    localparam int ROW_W = (PHASES > 1) ? $clog2(PHASES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [CNT_W-1:0]   req_count,
    input  logic [LEVEL_W-1:0] req_level,
    input  logic               req_jam,
    input  logic [LEVEL_W-1:0] jam_level,
    output logic               word_valid,
    input  logic               word_ready,
    output logic [WORD_W-1:0]  word_data,
    output logic               done
);
    typedef struct packed {
        logic               busy;
        logic [CNT_W-1:0]   remain;
        logic [LEVEL_W-1:0] level;
        logic               done;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  accept;
    logic [ROW_W-1:0] row;

    assign accept = ctl_q.busy && word_ready;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        if (!ctl_q.busy) begin
            if (req_valid) begin
                if (req_jam) begin
                    ctl_d.busy   = 1'b1;
                    ctl_d.remain = CNT_W'(LINE_WORDS);
                    ctl_d.level  = jam_level;
                end else if (req_count == '0) begin
                    ctl_d.done = 1'b1;
                end else begin
                    ctl_d.busy   = 1'b1;
                    ctl_d.remain = req_count;
                    ctl_d.level  = req_level;
                end
            end
        end else if (accept) begin
            ctl_d.remain = ctl_q.remain - 1'b1;
            if (ctl_q.remain == CNT_W'(1)) begin
                ctl_d.busy = 1'b0;
                ctl_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    premod_phase #(.PHASES(PHASES)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (accept),
        .row   (row)
    );

    premod_rom #(.PHASES(PHASES)) u_rom (
        .row   (row),
        .level (ctl_q.level),
        .word  (word_data)
    );

    assign req_ready  = !ctl_q.busy;
    assign word_valid = ctl_q.busy;
    assign done       = ctl_q.done;
endmodule

// File: rtl/premod_wordgen_chk.sv
module premod_wordgen_chk #(
    parameter int PHASES = 7,
    parameter int CNT_W  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [CNT_W-1:0] req_count,
    input logic             req_jam,
    input logic             word_valid,
    input logic             word_ready,
    input logic [31:0]      word_data,
    input logic             done
);
    a_r4_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !word_ready) |=> (word_valid && $stable(word_data)));

    a_r3_row_step: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_ready) |=> (!word_valid ||
            word_data[31:24] == (($past(word_data[31:24]) == 8'(PHASES - 1)) ?
                                 8'd0 : $past(word_data[31:24]) + 8'd1)));

    a_r2_pad: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (word_data[15:0] == 16'hC3A5));

    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !word_valid);

    a_r10_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> !req_ready);

    a_r9_zero_req: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_jam && req_count == '0) |=> (done && !word_valid));
endmodule

bind premod_wordgen premod_wordgen_chk #(.PHASES(PHASES), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_count  (req_count),
    .req_jam    (req_jam),
    .word_valid (word_valid),
    .word_ready (word_ready),
    .word_data  (word_data),
    .done       (done)
);

// File: tb/tb_premod_wordgen.sv
module tb_premod_wordgen;
    localparam int PHASES     = 7;
    localparam int CNT_W      = 8;
    localparam int LINE_WORDS = 159;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [CNT_W-1:0] req_count = '0;
    logic [3:0]       req_level = '0;
    logic             req_jam = 1'b0;
    logic [3:0]       jam_level = '0;
    logic             word_valid;
    logic             word_ready = 1'b0;
    logic [31:0]      word_data;
    logic             done;

    int checks = 0;
    int errors = 0;
    int exp_row = 0;

    always #10 clk = ~clk;

    premod_wordgen #(.PHASES(PHASES), .CNT_W(CNT_W), .LINE_WORDS(LINE_WORDS)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_count(req_count), .req_level(req_level), .req_jam(req_jam),
        .jam_level(jam_level), .word_valid(word_valid), .word_ready(word_ready),
        .word_data(word_data), .done(done)
    );

    function automatic logic [31:0] exp_word(input int row, input int lvl);
        return {8'(row), 8'(lvl), 16'hC3A5};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // {poke, stall, jam, count[7:0], level[3:0]}
    localparam int NV = 8;
    localparam logic [14:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b0, 8'd5,  4'd3},
        {1'b0, 1'b1, 1'b0, 8'd10, 4'd9},
        {1'b0, 1'b0, 1'b0, 8'd0,  4'd7},
        {1'b0, 1'b0, 1'b0, 8'd1,  4'd15},
        {1'b0, 1'b1, 1'b1, 8'd3,  4'd12},
        {1'b1, 1'b0, 1'b0, 8'd6,  4'd4},
        {1'b0, 1'b1, 1'b0, 8'd2,  4'd0},
        {1'b0, 1'b0, 1'b0, 8'd14, 4'd6}
    };

    task automatic run_req(input bit poke, input bit stall, input bit jam,
                           input int cnt, input int lvl);
        int exp_n, exp_lvl, got, row_before;
        bit seen_done;
        exp_n   = jam ? LINE_WORDS : cnt;
        exp_lvl = lvl;
        row_before = exp_row;
        @(negedge clk);
        req_valid = 1'b1;
        req_jam   = jam;
        req_count = CNT_W'(cnt);
        req_level = jam ? 4'(~lvl) : 4'(lvl);
        jam_level = jam ? 4'(lvl) : 4'(~lvl);
        @(negedge clk);
        if (poke) begin
            req_jam = 1'b1; req_level = 4'(lvl + 1); jam_level = 4'(lvl + 2); req_count = '0;
        end else begin
            req_valid = 1'b0;
        end
        got = 0;
        seen_done = 1'b0;
        for (int k = 0; k < 2000 && !seen_done; k++) begin
            if (done) begin
                seen_done = 1'b1;
                req_valid = 1'b0;
                check(!word_valid, "R8 valid low at done", 32'(word_valid), 0);
            end else begin
                if (word_valid) begin
                    check(word_data == exp_word(exp_row, exp_lvl),
                          jam ? "R7 jam word" : "R2 R3 R5 R6 word", word_data,
                          exp_word(exp_row, exp_lvl));
                    if (poke) check(!req_ready, "R10 ready low while busy",
                                    32'(req_ready), 0);
                    word_ready = stall ? (k % 3 != 1) : 1'b1;
                    if (word_ready) begin
                        got++;
                        exp_row = (exp_row + 1) % PHASES;
                    end
                end
                @(negedge clk);
            end
        end
        word_ready = 1'b0;
        check(seen_done, "R8 done seen", 32'(seen_done), 1);
        check(got == exp_n, jam ? "R7 jam count" : "R6 R9 word count", 32'(got), 32'(exp_n));
        if (cnt == 0 && !jam)
            check(exp_row == row_before, "R9 phase unchanged", 32'(exp_row), 32'(row_before));
        @(negedge clk);
        check(!done, "R8 done one cycle", 32'(done), 0);
        check(!word_valid, "R10 no extra request", 32'(word_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!word_valid && !done && req_ready, "R1 reset outputs",
              {29'b0, word_valid, done, req_ready}, 32'b001);
        rst_n = 1'b1;
        @(negedge clk);
        check(!word_valid && !done && req_ready, "R1 idle after reset",
              {29'b0, word_valid, done, req_ready}, 32'b001);

        for (int v = 0; v < NV; v++) begin
            run_req(VEC[v][14], VEC[v][13], VEC[v][12], int'(VEC[v][11:4]), int'(VEC[v][3:0]));
        end

        // R4: long stall holds word and phase
        @(negedge clk);
        req_valid = 1'b1; req_jam = 1'b0; req_count = 8'd2; req_level = 4'd11;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (5) @(negedge clk);
        check(word_valid && word_data == exp_word(exp_row, 11), "R4 stalled word held",
              word_data, exp_word(exp_row, 11));
        word_ready = 1'b1;
        @(negedge clk);
        exp_row = (exp_row + 1) % PHASES;
        check(word_data == exp_word(exp_row, 11), "R4 R3 step after stall",
              word_data, exp_word(exp_row, 11));
        @(negedge clk);
        exp_row = (exp_row + 1) % PHASES;
        word_ready = 1'b0;
        check(done, "R8 done after stall request", 32'(done), 1);
        @(negedge clk);

        // R1 again: reset returns phase to row 0
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        exp_row = 0;
        run_req(1'b0, 1'b0, 1'b0, 3, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule